// File: doc/BRIEF.md
# Repeating Block Copy Sequencer

This block moves a run of bytes from one place in memory to another. It works one byte per iteration, on the T-state timing of an 8-bit processor. A start strobe, taken while the block is idle, loads a source pointer, a destination pointer, a byte counter and the three incoming flag values H, N and PV. The same strobe latches two mode bits: repeat, and direction (increment or decrement). Each iteration does four things in order:

- fetch: the fixed opcode time
- read the source byte
- write the byte to the destination
- step both pointers and decrement the counter

In single mode the block runs one iteration and stops. In repeat mode it runs again while the counter stays non-zero. Every state takes a parameterised number of clocks, one clock per T-state.

States and transitions: `ST_IDLE` goes to `ST_FETCH` on start. `ST_FETCH` (FETCH_T clocks) goes to `ST_READ` (READ_T clocks), which goes to `ST_WRITE` (WRITE_T clocks). From `ST_WRITE` the block goes to `ST_TAIL_RPT` when repeat is latched and the counter stays non-zero after the decrement. Otherwise it goes to `ST_TAIL_END`. `ST_TAIL_RPT` (RPT_T clocks) returns to `ST_FETCH`. `ST_TAIL_END` (END_T clocks) returns to `ST_IDLE` and raises done.

Memory is a synchronous byte port: read data is returned one clock after the read strobe. The default costs are 8 + 3 + 3 = 14 T-states of transfer, plus 7 for a repeating iteration (21 in total) or 2 for the last one (16 in total).

Top module: `block_copy_seq`

## Requirements
- R1: A start pulse in `ST_IDLE` loads src_in, dst_in, cnt_in, h_in, n_in, pv_in, repeat_en and dir_dec. busy is 1 from the following cycle.
- R2: Each iteration reads the byte at the source pointer and writes that byte to the destination pointer. It then decrements byte_cnt by exactly one, modulo 2^CNT_W.
- R3: With dir_dec=0 both pointers increment by one per iteration. With dir_dec=1 both decrement by one. Both wrap modulo 2^ADDR_W.
- R4: flag_h and flag_n are cleared to 0 on every iteration, whether or not the operation repeats.
- R5: After each iteration, flag_pv is 1 if byte_cnt is non-zero and 0 if it is zero.
- R6: In repeat mode, an iteration that leaves the counter non-zero restarts from the fetch. It takes FETCH_T+READ_T+WRITE_T+RPT_T T-states, 21 by default.
- R7: The last iteration takes FETCH_T+READ_T+WRITE_T+END_T T-states, 16 by default. In single mode exactly one iteration is run, whatever the counter value.
- R8: A counter of zero at start in repeat mode performs 2^CNT_W transfers.
- R9: done is a one-cycle pulse in the first cycle with busy=0 after the sequence ends. iter_valid pulses after every iteration, with iter_tstates holding that iteration's T-state count.
- R10: A start pulse while busy is ignored. Pointers, counter, mode and results are unaffected.
- R11: mem_rd is high for exactly one cycle per iteration, and mem_wr is high for exactly one cycle per iteration. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, one T-state per cycle |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | start strobe, taken in idle only |
| repeat_en | input | 1 | 1: repeat until counter is zero |
| dir_dec | input | 1 | 1: pointers decrement, 0: increment |
| src_in | input | ADDR_W | initial source pointer |
| dst_in | input | ADDR_W | initial destination pointer |
| cnt_in | input | CNT_W | initial byte counter (0 means 2^CNT_W) |
| h_in | input | 1 | H flag value loaded at start |
| n_in | input | 1 | N flag value loaded at start |
| pv_in | input | 1 | PV flag value loaded at start |
| mem_addr | output | ADDR_W | memory address |
| mem_rd | output | 1 | read strobe, data due next cycle |
| mem_wr | output | 1 | write strobe |
| mem_wdata | output | 8 | write data |
| mem_rdata | input | 8 | read data |
| src_ptr | output | ADDR_W | current source pointer |
| dst_ptr | output | ADDR_W | current destination pointer |
| byte_cnt | output | CNT_W | current byte counter |
| flag_h | output | 1 | H flag |
| flag_n | output | 1 | N flag |
| flag_pv | output | 1 | PV flag |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle end pulse |
| iter_valid | output | 1 | one-cycle pulse per finished iteration |
| iter_tstates | output | 8 | T-states of the iteration just finished |

## Verification
The bench builds the block with ADDR_W=8 and CNT_W=8 and keeps the default T-state costs, so every iteration is checked against 21 or 16. Eight-bit pointers make wrap-around past 0xFF reachable with short blocks. They also let overlapping copies land inside a 256-byte model memory. The eight-bit counter brings the zero-count case within reach: it runs 256 transfers, 5371 T-states, instead of 65536.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int TS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_TAIL_RPT,
        ST_TAIL_END
    } bcs_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int FETCH_T = 8,
    parameter int READ_T  = 3,
    parameter int WRITE_T = 3,
    parameter int RPT_T   = 7,
    parameter int END_T   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic repeat_en,
    input  logic last_xfer,
    output logic load,
    output logic rd_en,
    output logic capture,
    output logic wr_en,
    output logic step,
    output logic iter_end,
    output logic busy,
    output logic done
);

    localparam int MAX_T = max_of(max_of(max_of(FETCH_T, READ_T), max_of(WRITE_T, RPT_T)), END_T);
    localparam int TC_W  = $clog2(MAX_T + 1);

    bcs_state_t      state, state_d;
    logic [TC_W-1:0] tcnt, tcnt_d;
    logic            rpt_q;
    logic            fin;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            rpt_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            tcnt  <= tcnt_d;
            done  <= fin;
            if (load) rpt_q <= repeat_en;
        end
    end

    // next state and T-state countdown
    always_comb begin
        state_d = state;
        tcnt_d  = tcnt - TC_W'(1);
        unique case (state)
            ST_IDLE: begin
                tcnt_d = '0;
                if (start) begin
                    state_d = ST_FETCH;
                    tcnt_d  = TC_W'(FETCH_T - 1);
                end
            end
            ST_FETCH: if (tcnt == '0) begin
                state_d = ST_READ;
                tcnt_d  = TC_W'(READ_T - 1);
            end
            ST_READ: if (tcnt == '0) begin
                state_d = ST_WRITE;
                tcnt_d  = TC_W'(WRITE_T - 1);
            end
            ST_WRITE: if (tcnt == '0) begin
                if (rpt_q && !last_xfer) begin
                    state_d = ST_TAIL_RPT;
                    tcnt_d  = TC_W'(RPT_T - 1);
                end else begin
                    state_d = ST_TAIL_END;
                    tcnt_d  = TC_W'(END_T - 1);
                end
            end
            ST_TAIL_RPT: if (tcnt == '0) begin
                state_d = ST_FETCH;
                tcnt_d  = TC_W'(FETCH_T - 1);
            end
            ST_TAIL_END: if (tcnt == '0) begin
                state_d = ST_IDLE;
                tcnt_d  = '0;
            end
        endcase
    end

    // strobes decoded from state and countdown
    always_comb begin
        load     = (state == ST_IDLE) && start;
        rd_en    = (state == ST_READ) && (tcnt == TC_W'(READ_T - 1));
        capture  = (state == ST_READ) && (tcnt == '0);
        wr_en    = (state == ST_WRITE) && (tcnt == TC_W'(WRITE_T - 1));
        step     = (state == ST_WRITE) && (tcnt == '0);
        fin      = (state == ST_TAIL_END) && (tcnt == '0);
        iter_end = fin || ((state == ST_TAIL_RPT) && (tcnt == '0));
        busy     = (state != ST_IDLE);
    end

endmodule

// File: rtl/bcs_regs.sv
module bcs_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              step,
    input  logic              dir_dec,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              h_in,
    input  logic              n_in,
    input  logic              pv_in,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag_h,
    output logic              flag_n,
    output logic              flag_pv,
    output logic [7:0]        data_q,
    output logic              last_xfer
);

    logic              dec_q;
    logic [ADDR_W-1:0] ptr_init [2];
    logic [ADDR_W-1:0] ptr_q    [2];

    assign ptr_init[0] = src_in;
    assign ptr_init[1] = dst_in;
    assign src_ptr     = ptr_q[0];
    assign dst_ptr     = ptr_q[1];
    // counter at 1 before the decrement: this transfer empties it (R5, R8)
    assign last_xfer   = (cnt == CNT_W'(1));

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)       ptr_q[g] <= '0;
            else if (load)    ptr_q[g] <= ptr_init[g];
            else if (step)    ptr_q[g] <= dec_q ? ptr_q[g] - ADDR_W'(1) : ptr_q[g] + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            dec_q   <= 1'b0;
            flag_h  <= 1'b0;
            flag_n  <= 1'b0;
            flag_pv <= 1'b0;
            data_q  <= '0;
        end else begin
            if (capture) data_q <= rdata;
            if (load) begin
                cnt     <= cnt_in;
                dec_q   <= dir_dec;
                flag_h  <= h_in;
                flag_n  <= n_in;
                flag_pv <= pv_in;
            end else if (step) begin
                cnt     <= cnt - CNT_W'(1);
                flag_h  <= 1'b0;
                flag_n  <= 1'b0;
                flag_pv <= !last_xfer;
            end
        end
    end

endmodule

// File: rtl/bcs_meter.sv
module bcs_meter
    import bcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            iter_end,
    output logic            iter_valid,
    output logic [TS_W-1:0] iter_tstates
);

    logic [TS_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= '0;
            iter_valid   <= 1'b0;
            iter_tstates <= '0;
        end else begin
            iter_valid <= iter_end;
            if (iter_end) begin
                iter_tstates <= run_q + TS_W'(1);
                run_q        <= '0;
            end else if (busy) begin
                run_q <= run_q + TS_W'(1);
            end
        end
    end

endmodule

// File: rtl/block_copy_seq.sv
module block_copy_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int FETCH_T = 8,
    parameter int READ_T  = 3,
    parameter int WRITE_T = 3,
    parameter int RPT_T   = 7,
    parameter int END_T   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              repeat_en,
    input  logic              dir_dec,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              h_in,
    input  logic              n_in,
    input  logic              pv_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              flag_h,
    output logic              flag_n,
    output logic              flag_pv,
    output logic              busy,
    output logic              done,
    output logic              iter_valid,
    output logic [TS_W-1:0]   iter_tstates
);

    logic load, rd_en, capture, wr_en, step, iter_end, last_xfer;

    bcs_ctrl #(
        .FETCH_T(FETCH_T), .READ_T(READ_T), .WRITE_T(WRITE_T),
        .RPT_T(RPT_T), .END_T(END_T)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .repeat_en(repeat_en),
        .last_xfer(last_xfer), .load(load), .rd_en(rd_en), .capture(capture),
        .wr_en(wr_en), .step(step), .iter_end(iter_end), .busy(busy), .done(done)
    );

    bcs_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .capture(capture), .step(step),
        .dir_dec(dir_dec), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .h_in(h_in), .n_in(n_in), .pv_in(pv_in), .rdata(mem_rdata),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt(byte_cnt),
        .flag_h(flag_h), .flag_n(flag_n), .flag_pv(flag_pv),
        .data_q(mem_wdata), .last_xfer(last_xfer)
    );

    bcs_meter u_meter (
        .clk(clk), .rst_n(rst_n), .busy(busy), .iter_end(iter_end),
        .iter_valid(iter_valid), .iter_tstates(iter_tstates)
    );

    assign mem_addr = rd_en ? src_ptr : dst_ptr;
    assign mem_rd   = rd_en;
    assign mem_wr   = wr_en;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int CNT_W     = 16,
    parameter int TOTAL_RPT = 21,
    parameter int TOTAL_END = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             iter_valid,
    input logic [7:0]       iter_tstates,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             flag_h,
    input logic             flag_n,
    input logic             flag_pv,
    input logic             mem_rd,
    input logic             mem_wr
);

    a_r2_cnt_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && byte_cnt != $past(byte_cnt)) |-> byte_cnt == $past(byte_cnt) - CNT_W'(1));

    a_r4_hn_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        iter_valid |-> (!flag_h && !flag_n));

    a_r5_pv_on_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_valid && !done) |-> flag_pv);

    a_r5_pv_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_valid && byte_cnt == '0) |-> !flag_pv);

    a_r6_repeat_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_valid && !done) |-> iter_tstates == 8'(TOTAL_RPT));

    a_r7_last_cost: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iter_valid && iter_tstates == 8'(TOTAL_END)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

endmodule

bind block_copy_seq bcs_checker #(
    .CNT_W(CNT_W),
    .TOTAL_RPT(FETCH_T + READ_T + WRITE_T + RPT_T),
    .TOTAL_END(FETCH_T + READ_T + WRITE_T + END_T)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .iter_valid(iter_valid),
    .iter_tstates(iter_tstates), .byte_cnt(byte_cnt), .flag_h(flag_h),
    .flag_n(flag_n), .flag_pv(flag_pv), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/block_copy_seq_tb.sv
`timescale 1ns/1ps
module block_copy_seq_tb;

    localparam int AW = 8;
    localparam int CW = 8;

    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] cnt;
        logic       rep;
        logic       dec;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 8'h80, 8'h05, 1'b1, 1'b0, 8'h11},
        '{8'h60, 8'h20, 8'h04, 1'b1, 1'b1, 8'h22},
        '{8'hF0, 8'h30, 8'h20, 1'b1, 1'b0, 8'h33},
        '{8'h40, 8'h41, 8'h06, 1'b1, 1'b0, 8'h44},
        '{8'h20, 8'h90, 8'h03, 1'b0, 1'b0, 8'h55},
        '{8'h05, 8'hC0, 8'h01, 1'b0, 1'b1, 8'h66}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, repeat_en = 1'b0, dir_dec = 1'b0;
    logic [AW-1:0] src_in = '0, dst_in = '0;
    logic [CW-1:0] cnt_in = '0;
    logic h_in = 1'b0, n_in = 1'b0, pv_in = 1'b0;
    logic [AW-1:0] mem_addr, src_ptr, dst_ptr;
    logic mem_rd, mem_wr, flag_h, flag_n, flag_pv, busy, done, iter_valid;
    logic [7:0] mem_wdata, iter_tstates;
    logic [7:0] mem_rdata = 8'h00;
    logic [CW-1:0] byte_cnt;

    always #2.5 clk = ~clk;

    block_copy_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .repeat_en(repeat_en), .dir_dec(dir_dec),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .h_in(h_in), .n_in(n_in),
        .pv_in(pv_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .byte_cnt(byte_cnt), .flag_h(flag_h), .flag_n(flag_n), .flag_pv(flag_pv),
        .busy(busy), .done(done), .iter_valid(iter_valid), .iter_tstates(iter_tstates)
    );

    // synchronous memory model, with a pattern fill on request
    logic [7:0] mem [256];
    logic       init_go = 1'b0;
    logic [7:0] init_seed = 8'h00;
    always @(posedge clk) begin
        if (init_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7) ^ init_seed;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (mem_wr) mem[mem_addr] <= mem_wdata;
        end
    end

    // monitor counters, read as differences by the tasks
    int busy_cyc = 0, n21 = 0, n16 = 0, nbad = 0, ndone = 0, nrd = 0, nwr = 0, nclash = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (iter_valid) begin
                if (iter_tstates == 8'd21) n21++;
                else if (iter_tstates == 8'd16) n16++;
                else nbad++;
            end
            if (done) ndone++;
            if (mem_rd) nrd++;
            if (mem_wr) nwr++;
            if (mem_rd && mem_wr) nclash++;
        end
    end

    int checks = 0, fails = 0;
    logic [7:0] exp_mem [256];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input vec_t v, input bit poke_busy);
        int k, s, d, c, mism, b0, r21, r16, rb, dn, rd0, wr0, cl0, wd;
        init_seed = v.seed;
        @(negedge clk) init_go = 1'b1;
        @(negedge clk) init_go = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        k = v.rep ? ((v.cnt == 0) ? 256 : int'(v.cnt)) : 1;
        s = v.src; d = v.dst; c = v.cnt;
        for (int i = 0; i < k; i++) begin
            exp_mem[d] = exp_mem[s];
            s = v.dec ? (s + 255) % 256 : (s + 1) % 256;
            d = v.dec ? (d + 255) % 256 : (d + 1) % 256;
            c = (c + 255) % 256;
        end
        b0 = busy_cyc; r21 = n21; r16 = n16; rb = nbad; dn = ndone;
        rd0 = nrd; wr0 = nwr; cl0 = nclash;
        src_in = v.src; dst_in = v.dst; cnt_in = v.cnt;
        repeat_en = v.rep; dir_dec = v.dec;
        h_in = 1'b1; n_in = 1'b1; pv_in = ~v.rep;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R1", "busy after start", busy, 1);
        chk("R1", "src loaded", src_ptr, v.src);
        chk("R1", "flag_h loaded", flag_h, 1);
        if (poke_busy) begin
            repeat (30) @(negedge clk);
            src_in = 8'hAA; dst_in = 8'h55; cnt_in = 8'h02; dir_dec = ~v.dec; repeat_en = 1'b0;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9 watchdog: done not seen, actual 0 expected 1");
        end
        repeat (3) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != exp_mem[i]) mism++;
        chk("R2", "memory mismatches", mism, 0);
        chk("R2", "final counter", byte_cnt, c);
        chk("R3", "final src", src_ptr, s);
        chk("R3", "final dst", dst_ptr, d);
        chk("R4", "flag_h", flag_h, 0);
        chk("R4", "flag_n", flag_n, 0);
        chk("R5", "flag_pv", flag_pv, (c != 0));
        chk("R6", "21-state iterations", n21 - r21, k - 1);
        chk("R7", "16-state iterations", n16 - r16, 1);
        chk("R7", "odd iteration costs", nbad - rb, 0);
        chk("R7", "total T-states", busy_cyc - b0, 21 * (k - 1) + 16);
        chk("R9", "done pulses", ndone - dn, 1);
        chk("R11", "reads", nrd - rd0, k);
        chk("R11", "writes", nwr - wr0, k);
        chk("R11", "rd/wr clash", nclash - cl0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R9", "reset busy", busy, 0);
        chk("R9", "reset done", done, 0);
        chk("R9", "reset iter_valid", iter_valid, 0);
        chk("R11", "reset mem_rd", mem_rd, 0);
        chk("R11", "reset mem_wr", mem_wr, 0);
        chk("R2", "reset counter", byte_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int j = 0; j < NV; j++) run(VECS[j], 1'b0);
        // R8: zero start count runs the full counter range
        run('{8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 8'h77}, 1'b0);
        // R8: zero start count, decrementing, pointers wrap below zero
        run('{8'h03, 8'h83, 8'h00, 1'b1, 1'b1, 8'h88}, 1'b0);
        // R10: a start pulse while busy must leave the run untouched
        run('{8'h30, 8'hB0, 8'h08, 1'b1, 1'b0, 8'h99}, 1'b1);
        // R7: single mode with counter zero does one transfer, PV set
        run('{8'hFF, 8'h10, 8'h00, 1'b0, 1'b0, 8'hAB}, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL global watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule